// File: doc/BRIEF.md
# Programmable Divided Countdown Timer

This block is a local interrupt timer. Software loads a 32-bit start value, and the counter then steps down once every 2^shift input clocks. The shift comes from a small divide-configuration register that uses a wrapped three-bit code. When the count reaches zero, the block raises a one-cycle interrupt request that carries the vector held in the local vector entry.

The local vector entry has three fields: the vector, a mask bit and a periodic bit. In one-shot mode the counter stops at zero. In periodic mode it holds zero for one step and then reloads the start value, so each period visits every value from the start value down to 0. All registers sit behind one write port and one combinational read port, and each port takes a two-bit register select.

Top module: `divtimer`

## Requirements
- R1: After reset every readable register returns 0, `irq_valid` is low and the counter is stopped.
- R2: Select 2 is the divide-configuration register. A write keeps only data bits 3, 1 and 0 (mask 0xB), and the other bits read back as zero.
- R3: The divide code is {cfg[3], cfg[1], cfg[0]}. The shift is (code + 1) mod 8, so code 0 divides by 2 and code 7 divides by 1. The counter steps once every 2^shift clocks.
- R4: A write to select 0 loads the start value and restarts the divider phase. The value appears on select 1 right after the write edge, and it reads N-k when k·2^shift clocks have passed since that edge. Writes to select 1 are ignored.
- R5: With a start value N ≥ 1, `irq_valid` is high for exactly one cycle, N·2^shift clocks after the write edge. During that cycle `irq_vector` equals bits 7:0 of the local vector entry.
- R6: In one-shot mode (entry bit 17 clear) the count stays at 0 after expiry, and no further requests are made.
- R7: In periodic mode (entry bit 17 set) the count reloads one step after reaching 0. Requests therefore repeat every (N+1)·2^shift clocks.
- R8: When entry bit 16 (mask) is set, expiry makes no request, but the count still runs down to 0.
- R9: A start value of 0 stops the timer, and no request is made, even in periodic mode.
- R10: A write to select 3 (the local vector entry, with fields at bits 7:0, 16 and 17) does not disturb the running count. Reading select 3 returns only those fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write register select: 0 start, 1 current (ignored), 2 divide, 3 vector entry |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read register select, same encoding as `wr_sel` |
| rd_data | output | 32 | Combinational read data |
| irq_valid | output | 1 | One-cycle interrupt request strobe |
| irq_vector | output | 8 | Vector sent with the request |

## Verification
Take the edge that captures a start-value write as edge 0. The current count reads N-k after edge k·2^shift. The request strobe is registered together with the count, so it is visible just after edge N·2^shift. In periodic mode the next request follows (N+1)·2^shift edges after the previous one. The bench drives writes on falling edges and counts falling edges from the write, and it samples both the strobe and the read port there, half a period after the register update. Where a write must have no effect, the count is read one edge after the write, and the bench expects exactly one step (divide-by-1) rather than a reload.

// File: rtl/divtimer_pkg.sv
`timescale 1ns/1ps
package divtimer_pkg;

   typedef enum logic [1:0] {
      SEL_START = 2'd0,
      SEL_CUR   = 2'd1,
      SEL_DIV   = 2'd2,
      SEL_ENTRY = 2'd3
   } reg_sel_e;

   localparam logic [3:0] DIV_KEEP_MASK = 4'hB;

   // wrapped divide code: code 7 gives shift 0, code 0 gives shift 1
   function automatic logic [2:0] code_to_shift(input logic [2:0] code);
      return code + 3'd1;
   endfunction

endpackage

// File: rtl/divtimer_decode.sv
`timescale 1ns/1ps
module divtimer_decode #(
   parameter int SHIFT_W = 3,
   localparam int PRE_W  = (1 << SHIFT_W) - 1
) (
   input  logic [SHIFT_W-1:0] code,
   output logic [PRE_W-1:0]   tick_mask
);
   import divtimer_pkg::*;

   logic [SHIFT_W-1:0] shift;

   assign shift = code_to_shift(code);

   // one mask bit per prescaler stage that must be all-ones for a tick
   for (genvar i = 0; i < PRE_W; i++) begin : g_mask
      assign tick_mask[i] = (shift > SHIFT_W'(i));
   end

endmodule

// File: rtl/divtimer_prescale.sv
`timescale 1ns/1ps
module divtimer_prescale #(
   parameter int PRE_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [PRE_W-1:0] tick_mask,
   output logic             tick
);
   logic [PRE_W-1:0] phase_q;

   always_ff @(posedge clk) begin
      if (!rst_n || restart) begin
         phase_q <= '0;
      end else begin
         phase_q <= phase_q + 1'b1;
      end
   end

   assign tick = &(phase_q | ~tick_mask);

endmodule

// File: rtl/divtimer_count.sv
`timescale 1ns/1ps
module divtimer_count #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   input  logic             periodic,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] reload,
   output logic             expire
);
   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] reload_q;
   logic             active_q;
   logic             at_zero;
   logic             at_one;

   assign at_zero = (count_q == '0);
   assign at_one  = (count_q == CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q  <= '0;
         reload_q <= '0;
         active_q <= 1'b0;
      end else if (load) begin
         count_q  <= load_val;
         reload_q <= load_val;
         active_q <= (load_val != '0);
      end else if (tick && active_q) begin
         if (!at_zero) begin
            count_q <= count_q - 1'b1;
            if (at_one && !periodic) begin
               active_q <= 1'b0;
            end
         end else if (periodic) begin
            count_q <= reload_q;
         end else begin
            active_q <= 1'b0;
         end
      end
   end

   assign expire = tick && active_q && at_one && !load;
   assign count  = count_q;
   assign reload = reload_q;

endmodule

// File: rtl/divtimer.sv
`timescale 1ns/1ps
module divtimer #(
   parameter int CNT_W        = 32,
   parameter int VEC_W        = 8,
   parameter int SHIFT_W      = 3,
   parameter int MASK_BIT     = 16,
   parameter int PERIODIC_BIT = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   input  logic [1:0]       rd_sel,
   output logic [CNT_W-1:0] rd_data,
   output logic             irq_valid,
   output logic [VEC_W-1:0] irq_vector
);
   import divtimer_pkg::*;

   localparam int PRE_W = (1 << SHIFT_W) - 1;

   if (SHIFT_W != 3) begin : g_bad_shift
      $error("divtimer: divide code is three bits wide");
   end
   if (VEC_W > MASK_BIT || MASK_BIT >= PERIODIC_BIT || PERIODIC_BIT >= CNT_W) begin : g_bad_fields
      $error("divtimer: vector entry fields overlap or exceed the data width");
   end
   if (CNT_W < 4) begin : g_bad_width
      $error("divtimer: data width too small for the divide register");
   end

   logic [3:0]       div_cfg_q;
   logic [VEC_W-1:0] ent_vec_q;
   logic             ent_mask_q;
   logic             ent_per_q;
   logic [PRE_W-1:0] tick_mask;
   logic             tick;
   logic             cnt_load;
   logic [CNT_W-1:0] cnt_value;
   logic [CNT_W-1:0] cnt_reload;
   logic             cnt_expire;
   logic             irq_q;
   logic [VEC_W-1:0] irq_vec_q;
   logic             wr_div;
   logic             wr_ent;

   assign cnt_load = wr_en && (reg_sel_e'(wr_sel) == SEL_START);
   assign wr_div   = wr_en && (reg_sel_e'(wr_sel) == SEL_DIV);
   assign wr_ent   = wr_en && (reg_sel_e'(wr_sel) == SEL_ENTRY);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_cfg_q  <= '0;
         ent_vec_q  <= '0;
         ent_mask_q <= 1'b0;
         ent_per_q  <= 1'b0;
      end else begin
         if (wr_div) begin
            div_cfg_q <= wr_data[3:0] & DIV_KEEP_MASK;
         end
         if (wr_ent) begin
            ent_vec_q  <= wr_data[VEC_W-1:0];
            ent_mask_q <= wr_data[MASK_BIT];
            ent_per_q  <= wr_data[PERIODIC_BIT];
         end
      end
   end

   divtimer_decode #(.SHIFT_W(SHIFT_W)) u_decode (
      .code      ({div_cfg_q[3], div_cfg_q[1:0]}),
      .tick_mask (tick_mask)
   );

   divtimer_prescale #(.PRE_W(PRE_W)) u_prescale (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (cnt_load),
      .tick_mask (tick_mask),
      .tick      (tick)
   );

   divtimer_count #(.CNT_W(CNT_W)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_load),
      .load_val (wr_data),
      .tick     (tick),
      .periodic (ent_per_q),
      .count    (cnt_value),
      .reload   (cnt_reload),
      .expire   (cnt_expire)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_q     <= 1'b0;
         irq_vec_q <= '0;
      end else begin
         irq_q <= cnt_expire && !ent_mask_q;
         if (cnt_expire && !ent_mask_q) begin
            irq_vec_q <= ent_vec_q;
         end
      end
   end

   always_comb begin
      rd_data = '0;
      unique case (reg_sel_e'(rd_sel))
         SEL_START: rd_data = cnt_reload;
         SEL_CUR:   rd_data = cnt_value;
         SEL_DIV:   rd_data[3:0] = div_cfg_q;
         SEL_ENTRY: begin
            rd_data[VEC_W-1:0]   = ent_vec_q;
            rd_data[MASK_BIT]     = ent_mask_q;
            rd_data[PERIODIC_BIT] = ent_per_q;
         end
         default: rd_data = '0;
      endcase
   end

   assign irq_valid  = irq_q;
   assign irq_vector = irq_vec_q;

endmodule

// File: rtl/divtimer_chk.sv
`timescale 1ns/1ps
module divtimer_chk #(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             load,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] reload,
   input logic             periodic,
   input logic             masked,
   input logic             irq_valid
);
   AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |=> !irq_valid);  // R5

   AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> (cnt == '0));  // R5

   AST_MASK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> !$past(masked));  // R8

   AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !periodic && cnt == '0) |=> (cnt == '0));  // R6

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> (cnt == $past(cnt) || cnt == $past(cnt) - 1'b1
                 || ($past(cnt) == '0 && cnt == reload)));  // R7

   AST_ZERO_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> (reload != '0));  // R9
endmodule

bind divtimer divtimer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .load      (cnt_load),
   .cnt       (cnt_value),
   .reload    (cnt_reload),
   .periodic  (ent_per_q),
   .masked    (ent_mask_q),
   .irq_valid (irq_valid)
);

// File: tb/divtimer_tb.sv
`timescale 1ns/1ps
module divtimer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = '0;
   logic [31:0] wr_data = '0;
   logic [1:0]  rd_sel = '0;
   logic [31:0] rd_data;
   logic        irq_valid;
   logic [7:0]  irq_vector;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   divtimer u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_sel(rd_sel), .rd_data(rd_data), .irq_valid(irq_valid), .irq_vector(irq_vector)
   );

   function automatic int div_of(input logic [3:0] cfg);
      logic [2:0] code;
      code = {cfg[3], cfg[1:0]};
      return 1 << ((int'(code) + 1) % 8);
   endfunction

   function automatic logic [3:0] cfg_of(input int code, input bit junk);
      logic [2:0] c;
      c = 3'(code);
      return {c[2], junk, c[1:0]};
   endfunction

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // called at a falling edge; returns at the falling edge after the write edge
   task automatic wr(input logic [1:0] sel, input logic [31:0] data);
      wr_en = 1'b1; wr_sel = sel; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] sel, output logic [31:0] val);
      rd_sel = sel;
      #1 val = rd_data;
   endtask

   task automatic wait_irq(input int max, output int k, output logic [7:0] vec);
      k = 0;
      vec = '0;
      for (int i = 1; i <= max; i++) begin
         @(negedge clk);
         if (irq_valid) begin
            k = i;
            vec = irq_vector;
            break;
         end
      end
   endtask

   task automatic quiet(input int cycles, output int hits);
      hits = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (irq_valid) hits++;
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(20 * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end

   initial begin
      logic [31:0] v;
      logic [31:0] c;
      logic [7:0]  vec;
      int k, hits, d, n;
      void'($urandom(32'd4242));

      repeat (3) @(negedge clk);
      // R1 reset state
      for (int s = 0; s < 4; s++) begin
         rd(2'(s), v);
         check(v == 0, "R1 register reads zero", v, 0);
      end
      check(irq_valid == 1'b0, "R1 no request", irq_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      quiet(20, hits);
      check(hits == 0, "R1 stopped after reset", hits, 0);

      // R2 divide register keeps bits 3,1,0
      wr(2'd2, 32'hFFFF_FFFF);
      rd(2'd2, v);
      check(v == 32'hB, "R2 divide readback", v, 32'hB);
      wr(2'd2, 32'h0000_0004);
      rd(2'd2, v);
      check(v == 32'h0, "R2 bit 2 dropped", v, 0);

      // R3 / R5 every divide code, one-shot
      for (int code = 0; code < 8; code++) begin
         d = div_of(cfg_of(code, 1'b0));
         wr(2'd2, {28'd0, cfg_of(code, 1'b0)});
         wr(2'd3, 32'h40 + code);
         wr(2'd0, 32'd3);
         wait_irq(3 * d + 10, k, vec);
         check(k == 3 * d, "R3 expiry time per divide code", k, 3 * d);
         check(vec == 8'(32'h40 + code), "R5 vector", vec, 32'h40 + code);
         @(negedge clk);
         check(irq_valid == 1'b0, "R5 single-cycle strobe", irq_valid, 0);
      end

      // R4 count readback and ignored write to current count (divide by 1)
      wr(2'd2, 32'hB);
      wr(2'd3, 32'h21);
      wr(2'd0, 32'd50);
      rd(2'd1, v);
      check(v == 50, "R4 loaded value", v, 50);
      rd(2'd0, v);
      check(v == 50, "R4 start readback", v, 50);
      repeat (10) @(negedge clk);
      rd(2'd1, v);
      check(v == 40, "R4 count after 10 clocks", v, 40);
      rd(2'd1, c);
      wr(2'd1, 32'd5);
      rd(2'd1, v);
      check(v == c - 1, "R4 write to current ignored", v, c - 1);

      // R10 entry write leaves count running
      rd(2'd1, c);
      wr(2'd3, 32'hFFFF_FF77);
      rd(2'd1, v);
      check(v == c - 1, "R10 entry write no restart", v, c - 1);
      rd(2'd3, v);
      check(v == 32'h0003_0077, "R10 entry readback fields", v, 32'h0003_0077);
      wr(2'd3, 32'h21);
      wr(2'd0, 32'd50);
      rd(2'd1, v);
      check(v == 50, "R4 rewrite restarts", v, 50);

      // R6 one-shot stays at zero
      wr(2'd0, 32'd5);
      wait_irq(20, k, vec);
      check(k == 5, "R6 one-shot expiry", k, 5);
      quiet(60, hits);
      check(hits == 0, "R6 no repeat", hits, 0);
      rd(2'd1, v);
      check(v == 0, "R6 count held at zero", v, 0);

      // R7 periodic, divide by 2
      wr(2'd2, 32'h0);
      wr(2'd3, 32'h0002_0055);
      wr(2'd0, 32'd4);
      wait_irq(30, k, vec);
      check(k == 8, "R7 first periodic expiry", k, 8);
      wait_irq(30, k, vec);
      check(k == 10, "R7 periodic interval", k, 10);
      check(vec == 8'h55, "R7 periodic vector", vec, 8'h55);
      wait_irq(30, k, vec);
      check(k == 10, "R7 periodic interval repeat", k, 10);

      // R9 zero start stops even in periodic mode
      wr(2'd0, 32'd0);
      quiet(80, hits);
      check(hits == 0, "R9 zero start silent", hits, 0);
      rd(2'd1, v);
      check(v == 0, "R9 count zero", v, 0);

      // R8 masked expiry
      wr(2'd2, 32'hB);
      wr(2'd3, 32'h0001_0033);
      wr(2'd0, 32'd6);
      quiet(30, hits);
      check(hits == 0, "R8 masked no request", hits, 0);
      rd(2'd1, v);
      check(v == 0, "R8 count still ran", v, 0);

      // random trials, bit 2 of the divide write randomised
      wr(2'd3, 32'h0);
      for (int t = 0; t < 14; t++) begin
         int code;
         logic [3:0] cfg;
         logic [7:0] rv;
         code = int'($urandom_range(0, 7));
         cfg  = cfg_of(code, 1'($urandom_range(0, 1)));
         n    = int'($urandom_range(1, 12));
         rv   = 8'($urandom_range(0, 255));
         d    = div_of(cfg);
         wr(2'd2, {28'd0, cfg});
         wr(2'd3, {24'd0, rv});
         wr(2'd0, 32'(n));
         wait_irq(n * d + 10, k, vec);
         check(k == n * d, "R3 random expiry time", k, n * d);
         check(vec == rv, "R5 random vector", vec, rv);
      end

      finish_run();
   end
endmodule